// File: doc/BRIEF.md
# Per-Hart Performance Counter Bank with Group-Shared Cycle Counter

This block holds the hardware counters for a set of harts. Each hart owns a 64-bit retired-instruction counter, a row of 64-bit event counters and a private counter-stop register. The one exception to that ownership is the cycle counter. Harts that are placed in the same sharing group use one physical cycle counter and one physical stop bit for it. When any member of the group writes either of them, every member of the group sees the new value on its next read.

Each hart has its own register port. The port carries an address, a write enable and 64-bit write data, and read data comes back combinationally for the address on the port. Each hart also has a pulse input for retired instructions and a vector of event pulses. The group assignment of every hart is fixed by a parameter. A per-hart mask output reports which harts share that hart's cycle counter. The wall-clock time value passes straight through to the read port, and no stop bit can freeze it.

Top module: `hpc_counter_unit`

## Requirements
- R1: Each hart reads its cycle counter at address 0, its retired-instruction counter at address 2 and event counter n at address n, for n from 3 to 2+NUM_EVT. Every counter is 64 bits wide. The retired-instruction counter adds 1 on each clock that has the hart's retire pulse high. Event counter n adds 1 on each clock that has event bit n-3 of the hart high.
- R2: When its stop bit is clear, a counter advances. The cycle counter advances by 1 on every clock.
- R3: When its stop bit is set, a counter holds its value. The stop register sits at address 32: bit 0 stops the cycle counter, bit 2 stops the retired-instruction counter, and bit n stops event counter n.
- R4: A write to a counter address sets that counter to the written value on the following clock. The write replaces any increment from the same clock, and counting continues from the written value.
- R5: All harts with the same group number read one cycle counter. A write to it from any member is visible to every member. Harts in different groups have independent cycle counters.
- R6: Bit 0 of the stop register is shared within a group in the same way. Bits 2 and above, and the retired-instruction and event counters, are private to each hart.
- R7: When two or more harts of one group write the shared cycle counter in the same clock, the hart with the lowest index wins. The same rule applies to bit 0 of the stop register.
- R8: Bit k of hart h's field of `share_mask` (flat bit h*NUM_HARTS+k) is 1 exactly when harts h and k have the same group number.
- R9: Address 1 returns `time_in` unchanged. Writes to address 1 are ignored. Bit 1 of the stop register always reads 0, and no stop bit affects the time value.
- R10: With INH_EN = 0, the stop register reads 0, writes to it are ignored, and every counter advances as if all stop bits were clear.
- R11: Synchronous reset clears every counter and every stop bit to 0.
- R12: Addresses that map to no counter or register (above 2+NUM_EVT other than 32) read 0, and writes to them change no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_in | input | 64 | Wall-clock time value shown at address 1 |
| csr_addr | input | 6*NUM_HARTS | Per-hart register address, hart h at bits [6h+5:6h] |
| csr_we | input | NUM_HARTS | Per-hart write enable |
| csr_wdata | input | 64*NUM_HARTS | Per-hart write data |
| retire | input | NUM_HARTS | Per-hart retired-instruction pulse |
| evt | input | NUM_EVT*NUM_HARTS | Per-hart event pulses, hart h at bits [NUM_EVT*h +: NUM_EVT] |
| csr_rdata | output | 64*NUM_HARTS | Per-hart read data for the addressed register |
| share_mask | output | NUM_HARTS*NUM_HARTS | Per-hart mask of the harts that share its cycle counter |

## Verification
The assertions assume that reset is asserted at time zero and held for at least one clock. They also assume that hart 0's group contains no hart that writes the cycle counter in the same clock as hart 0 with different data, because hart 0 always wins that contest. The stimulus changes inputs only on falling edges and holds each write for exactly one clock. It never writes the shared cycle counter from a hart outside the group whose cycle value a check is about to read. This keeps every expected value a plain count of rising edges since the last write or the last change of a stop bit.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
    localparam int CNT_W     = 64;
    localparam int ADDR_W    = 6;
    localparam int MAX_EVT   = 29;
    localparam int A_CYCLE   = 0;
    localparam int A_TIME    = 1;
    localparam int A_INSTRET = 2;
    localparam int A_EVT0    = 3;
    localparam int A_STOP    = 32;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        cnt_t  wdata;
    } csr_req_t;

    // Implemented private stop bits: instret and the present event counters.
    function automatic logic [31:0] priv_stop_mask(int ne);
        logic [31:0] m;
        m = 32'h0000_0004;
        for (int i = 0; i < ne; i++) m[A_EVT0+i] = 1'b1;
        return m;
    endfunction

    function automatic logic is_wr(csr_req_t r, int a);
        return r.we && (r.addr == addr_t'(a));
    endfunction
endpackage

// File: rtl/hpc_counter.sv
module hpc_counter
    import hpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic hold,
    input  logic wr,
    input  cnt_t wdata,
    output cnt_t val
);
    always_ff @(posedge clk) begin
        if (rst)               val <= '0;
        else if (wr)           val <= wdata;
        else if (inc && !hold) val <= val + cnt_t'(1);
    end
endmodule

// File: rtl/hpc_cycle_group.sv
module hpc_cycle_group
    import hpc_pkg::*;
#(
    parameter int NH = 4,
    parameter int GW = 2,
    parameter logic [NH*GW-1:0] GROUP_ID = '0,
    parameter int G = 0,
    parameter bit INH_EN = 1'b1
)(
    input  logic     clk,
    input  logic     rst,
    input  csr_req_t req [NH],
    output cnt_t     cyc,
    output logic     cy_stop
);
    logic cyc_wr, stop_wr, stop_q;
    cnt_t cyc_wd;
    logic stop_wd;

    // Scan from the top so the lowest-index writer is assigned last.
    always_comb begin
        cyc_wr  = 1'b0;
        cyc_wd  = '0;
        stop_wr = 1'b0;
        stop_wd = 1'b0;
        for (int h = NH - 1; h >= 0; h--) begin
            if (GROUP_ID[h*GW +: GW] == GW'(G)) begin
                if (is_wr(req[h], A_CYCLE)) begin
                    cyc_wr = 1'b1;
                    cyc_wd = req[h].wdata;
                end
                if (is_wr(req[h], A_STOP)) begin
                    stop_wr = 1'b1;
                    stop_wd = req[h].wdata[0];
                end
            end
        end
    end

    generate
        if (INH_EN) begin : g_stop
            always_ff @(posedge clk) begin
                if (rst)          stop_q <= 1'b0;
                else if (stop_wr) stop_q <= stop_wd;
            end
        end else begin : g_nostop
            assign stop_q = 1'b0;
        end
    endgenerate

    assign cy_stop = stop_q;

    hpc_counter u_cyc (
        .clk(clk), .rst(rst), .inc(1'b1), .hold(stop_q),
        .wr(cyc_wr), .wdata(cyc_wd), .val(cyc)
    );
endmodule

// File: rtl/hpc_hart_bank.sv
module hpc_hart_bank
    import hpc_pkg::*;
#(
    parameter int NE = 29,
    parameter bit INH_EN = 1'b1
)(
    input  logic                     clk,
    input  logic                     rst,
    input  csr_req_t                 req,
    input  logic                     retire,
    input  logic [NE-1:0]            evt,
    output cnt_t                     instret,
    output logic [NE-1:0][CNT_W-1:0] evt_val,
    output logic [31:0]              stop_priv
);
    localparam logic [31:0] PMASK = priv_stop_mask(NE);

    generate
        if (INH_EN) begin : g_stop
            always_ff @(posedge clk) begin
                if (rst)                      stop_priv <= '0;
                else if (is_wr(req, A_STOP))  stop_priv <= req.wdata[31:0] & PMASK;
            end
        end else begin : g_nostop
            assign stop_priv = '0;
        end
    endgenerate

    hpc_counter u_instret (
        .clk(clk), .rst(rst), .inc(retire), .hold(stop_priv[A_INSTRET]),
        .wr(is_wr(req, A_INSTRET)), .wdata(req.wdata), .val(instret)
    );

    generate
        for (genvar e = 0; e < NE; e++) begin : g_evt
            hpc_counter u_evt (
                .clk(clk), .rst(rst), .inc(evt[e]), .hold(stop_priv[A_EVT0+e]),
                .wr(is_wr(req, A_EVT0 + e)), .wdata(req.wdata), .val(evt_val[e])
            );
        end
    endgenerate
endmodule

// File: rtl/hpc_counter_unit.sv
module hpc_counter_unit
    import hpc_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int NUM_EVT = 29,
    parameter bit INH_EN = 1'b1,
    parameter int GW = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1,
    parameter logic [NUM_HARTS*GW-1:0] GROUP_ID = 8'b01_01_00_00
)(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [CNT_W-1:0]               time_in,
    input  logic [ADDR_W*NUM_HARTS-1:0]    csr_addr,
    input  logic [NUM_HARTS-1:0]           csr_we,
    input  logic [CNT_W*NUM_HARTS-1:0]     csr_wdata,
    input  logic [NUM_HARTS-1:0]           retire,
    input  logic [NUM_EVT*NUM_HARTS-1:0]   evt,
    output logic [CNT_W*NUM_HARTS-1:0]     csr_rdata,
    output logic [NUM_HARTS*NUM_HARTS-1:0] share_mask
);
    localparam int NH = NUM_HARTS;
    localparam int NG = 1 << GW;

    csr_req_t req [NH];
    cnt_t     grp_cyc  [NG];
    logic     grp_stop [NG];
    cnt_t     hart_cyc [NH];
    logic     hart_cystop [NH];
    cnt_t     instret  [NH];
    logic [NUM_EVT-1:0][CNT_W-1:0] evt_val [NH];
    logic [31:0] stop_priv [NH];

    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            hpc_cycle_group #(
                .NH(NH), .GW(GW), .GROUP_ID(GROUP_ID), .G(g), .INH_EN(INH_EN)
            ) u_grp (
                .clk(clk), .rst(rst), .req(req),
                .cyc(grp_cyc[g]), .cy_stop(grp_stop[g])
            );
        end

        for (genvar h = 0; h < NH; h++) begin : g_hart
            localparam logic [GW-1:0] MYG = GROUP_ID[h*GW +: GW];

            assign req[h].we    = csr_we[h];
            assign req[h].addr  = csr_addr[h*ADDR_W +: ADDR_W];
            assign req[h].wdata = csr_wdata[h*CNT_W +: CNT_W];
            assign hart_cyc[h]    = grp_cyc[MYG];
            assign hart_cystop[h] = grp_stop[MYG];

            for (genvar k = 0; k < NH; k++) begin : g_mask
                assign share_mask[h*NH+k] = (GROUP_ID[k*GW +: GW] == MYG);
            end

            hpc_hart_bank #(.NE(NUM_EVT), .INH_EN(INH_EN)) u_bank (
                .clk(clk), .rst(rst), .req(req[h]),
                .retire(retire[h]), .evt(evt[h*NUM_EVT +: NUM_EVT]),
                .instret(instret[h]), .evt_val(evt_val[h]),
                .stop_priv(stop_priv[h])
            );

            always_comb begin
                cnt_t rd;
                rd = '0;
                if (req[h].addr == addr_t'(A_CYCLE))        rd = hart_cyc[h];
                else if (req[h].addr == addr_t'(A_TIME))    rd = time_in;
                else if (req[h].addr == addr_t'(A_INSTRET)) rd = instret[h];
                else if (req[h].addr == addr_t'(A_STOP))
                    rd = {32'b0, stop_priv[h][31:2], 1'b0, hart_cystop[h]};
                for (int e = 0; e < NUM_EVT; e++)
                    if (req[h].addr == addr_t'(A_EVT0 + e)) rd = evt_val[h][e];
                csr_rdata[h*CNT_W +: CNT_W] = rd;
            end
        end
    endgenerate
endmodule

// File: rtl/hpc_counter_unit_chk.sv
module hpc_counter_unit_chk #(
    parameter int NH = 4
)(
    input logic                clk,
    input logic                rst,
    input logic [63:0]         time_in,
    input logic [6*NH-1:0]     csr_addr,
    input logic [NH-1:0]       csr_we,
    input logic [64*NH-1:0]    csr_wdata,
    input logic [64*NH-1:0]    csr_rdata,
    input logic [NH*NH-1:0]    share_mask,
    input logic [63:0]         cyc0,
    input logic                cyc0_stop
);
    logic grp0_wr;
    always_comb begin
        grp0_wr = 1'b0;
        for (int k = 0; k < NH; k++)
            if (share_mask[k] && csr_we[k] && csr_addr[k*6 +: 6] == 6'd0)
                grp0_wr = 1'b1;
    end

    AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!grp0_wr && !cyc0_stop) |=> cyc0 == $past(cyc0) + 64'd1); // R2

    AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!grp0_wr && cyc0_stop) |=> $stable(cyc0)); // R3

    AST_CYC_WRITE: assert property (@(posedge clk) disable iff (rst)
        (csr_we[0] && csr_addr[5:0] == 6'd0) |=> cyc0 == $past(csr_wdata[63:0])); // R4

    AST_TIME_PASS: assert property (@(posedge clk) disable iff (rst)
        (csr_addr[5:0] == 6'd1) |-> csr_rdata[63:0] == time_in); // R9

    generate
        for (genvar k = 1; k < NH; k++) begin : g_coh
            AST_GROUP_COHERENT: assert property (@(posedge clk) disable iff (rst)
                (share_mask[k] && csr_addr[5:0] == 6'd0 && csr_addr[k*6 +: 6] == 6'd0)
                |-> csr_rdata[k*64 +: 64] == csr_rdata[63:0]); // R5
        end
    endgenerate
endmodule

bind hpc_counter_unit hpc_counter_unit_chk #(.NH(NUM_HARTS)) u_chk (
    .clk(clk), .rst(rst), .time_in(time_in), .csr_addr(csr_addr),
    .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .share_mask(share_mask), .cyc0(hart_cyc[0]), .cyc0_stop(hart_cystop[0])
);

// File: tb/hpc_counter_unit_tb.sv
`timescale 1ns/1ps
module hpc_counter_unit_tb;
    localparam int NH = 4;
    localparam int NE = 29;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [63:0]      time_in = 64'hDEAD_BEEF_0000_1234;
    logic [6*NH-1:0]  csr_addr = '0;
    logic [NH-1:0]    csr_we = '0;
    logic [64*NH-1:0] csr_wdata = '0;
    logic [NH-1:0]    retire = '0;
    logic [NE*NH-1:0] evt = '0;
    logic [64*NH-1:0] rd_a, rd_b;
    logic [NH*NH-1:0] mask_a, mask_b;

    always #2.5 clk = ~clk;

    hpc_counter_unit u_dut (
        .clk(clk), .rst(rst), .time_in(time_in), .csr_addr(csr_addr),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .retire(retire), .evt(evt),
        .csr_rdata(rd_a), .share_mask(mask_a)
    );

    hpc_counter_unit #(.INH_EN(1'b0)) u_dut_noinh (
        .clk(clk), .rst(rst), .time_in(time_in), .csr_addr(csr_addr),
        .csr_we(csr_we), .csr_wdata(csr_wdata), .retire(retire), .evt(evt),
        .csr_rdata(rd_b), .share_mask(mask_b)
    );

    typedef struct {
        bit          alt;
        int          hart;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    event  ev_sample;
    int vectors = 0;
    int miscompares = 0;

    // Monitor: pops expected items and compares against the read port.
    initial begin
        forever begin
            @(ev_sample);
            while (sb.size() > 0) begin
                item_t it;
                logic [63:0] got;
                it  = sb.pop_front();
                got = it.alt ? rd_b[it.hart*64 +: 64] : rd_a[it.hart*64 +: 64];
                vectors++;
                if (got !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s hart%0d got=%h exp=%h", it.req, it.hart, got, it.exp);
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit alt, int h, int a, logic [63:0] e, string r);
        csr_addr[h*6 +: 6] = a[5:0];
        #0.1;
        sb.push_back('{alt, h, e, r});
        ->ev_sample;
        wait (sb.size() == 0);
    endtask

    task automatic wr(int h, int a, logic [63:0] d);
        csr_we[h] = 1'b1;
        csr_addr[h*6 +: 6] = a[5:0];
        csr_wdata[h*64 +: 64] = d;
    endtask

    task automatic wr_end();
        csr_we = '0;
    endtask

    task automatic mask_chk(int h, logic [NH-1:0] e, string r);
        vectors++;
        if (mask_a[h*NH +: NH] !== e) begin
            miscompares++;
            $display("FAIL %s mask hart%0d got=%b exp=%b", r, h, mask_a[h*NH +: NH], e);
        end
    endtask

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        step(2);
        chk(0, 0, 0, 64'd0, "R11");
        chk(0, 3, 2, 64'd0, "R11");
        chk(0, 1, 32, 64'd0, "R11");
        rst = 1'b0;
        step(4);
        chk(0, 0, 0, 64'd4, "R2");
        chk(0, 1, 0, 64'd4, "R5");

        // R4 write from hart2 into group 1, visible to hart3 (R5)
        wr(2, 0, 64'd1000); step(1); wr_end();
        chk(0, 3, 0, 64'd1000, "R4");
        chk(0, 2, 0, 64'd1000, "R5");
        step(3);
        chk(0, 2, 0, 64'd1003, "R4");
        chk(0, 0, 0, 64'd8, "R5");

        // R3/R6: hart1 sets the shared cycle stop bit of group 0
        wr(1, 32, 64'd1); step(1); wr_end();
        step(3);
        chk(0, 0, 0, 64'd9, "R3");
        chk(0, 0, 32, 64'd1, "R6");
        chk(0, 2, 0, 64'd1007, "R6");
        chk(0, 2, 32, 64'd0, "R6");
        chk(1, 0, 0, 64'd12, "R10");
        chk(1, 0, 32, 64'd0, "R10");

        // R1 instret, private stop (R6)
        retire[0] = 1'b1; step(3); retire = '0;
        chk(0, 0, 2, 64'd3, "R1");
        chk(0, 1, 2, 64'd0, "R6");
        wr(0, 32, 64'd5); step(1); wr_end();
        retire = 2'b11; step(2); retire = '0;
        chk(0, 0, 2, 64'd3, "R3");
        chk(0, 1, 2, 64'd2, "R6");

        // R1 event counters on hart3
        evt[3*NE + 0] = 1'b1; step(2); evt = '0;
        chk(0, 3, 3, 64'd2, "R1");
        evt[3*NE + 28] = 1'b1; step(1); evt = '0;
        chk(0, 3, 31, 64'd1, "R1");
        wr(3, 32, 64'h8000_0000); step(1); wr_end();
        evt[3*NE + 28] = 1'b1; step(2); evt = '0;
        chk(0, 3, 31, 64'd1, "R3");
        chk(0, 3, 3, 64'd2, "R6");

        // R7 simultaneous writes, lowest index wins
        wr(0, 0, 64'd500); wr(1, 0, 64'd700); step(1); wr_end();
        chk(0, 1, 0, 64'd500, "R7");
        wr(0, 32, 64'd0); wr(1, 32, 64'd1); step(1); wr_end();
        step(2);
        chk(0, 1, 0, 64'd502, "R7");
        chk(0, 0, 32, 64'd0, "R7");

        // R9 time pass-through and bit 1 of the stop register
        wr(2, 1, 64'd0); step(1); wr_end();
        chk(0, 2, 1, 64'hDEAD_BEEF_0000_1234, "R9");
        wr(2, 32, '1); step(1); wr_end();
        chk(0, 2, 32, 64'h0000_0000_FFFF_FFFD, "R9");
        chk(0, 3, 32, 64'h0000_0000_8000_0001, "R6");
        chk(0, 2, 1, 64'hDEAD_BEEF_0000_1234, "R9");

        // R12 unmapped addresses
        wr(0, 40, 64'd123); step(1); wr_end();
        chk(0, 0, 40, 64'd0, "R12");
        chk(0, 0, 33, 64'd0, "R12");
        chk(0, 0, 2, 64'd3, "R12");

        // R8 sharing masks
        mask_chk(0, 4'b0011, "R8");
        mask_chk(1, 4'b0011, "R8");
        mask_chk(2, 4'b1100, "R8");
        mask_chk(3, 4'b1100, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule